// File: doc/BRIEF.md
# Dual-Channel Waveform Timer

An 8-bit counter with two compare channels, A and B, and a waveform generator that drives one output pin per channel. A 3-bit mode field selects the counting scheme: free running, clear on compare, fast PWM, or phase-correct (up/down) PWM. The counter moves one step per cycle in which the `tick` input is high. Any prescaling is done outside the block, and `tick` is its count enable.

Software reaches the block through a plain register port. A write takes effect at the clock edge on which `reg_wr` is high. A read is combinational from `reg_addr`. There is no stream data path, so the port has no valid/ready handshake and no back-pressure: every write is accepted in the cycle it is presented. Each pin has an override-enable that tells the surrounding pad logic to hand the pin to the timer. Three one-cycle flags report overflow and the two compare matches.

Top module: `wavetimer8`

## Requirements
- R1: After reset every register reads 0, both pins and both override-enables are low, and all three flags are low.
- R2: Register addresses: 0 = control A, 1 = control B, 2 = compare A, 3 = compare B, 4 = count. Control A holds the channel A output code in bits 7:6, the channel B code in bits 5:4 and mode bits 1:0 in bits 1:0. Bits 3:2 of control A read 0. Control B holds mode bit 2 in bit 0, and its other bits read 0. Compare and count registers read back the value written.
- R3: Mode encoding (bit2..bit0): 000 normal, 010 clear-on-compare, 011 fast PWM with TOP=0xFF, 111 fast PWM with TOP=compare A, 001 phase-correct with TOP=0xFF, 101 phase-correct with TOP=compare A. Codes 100 and 110 act as normal. In normal mode the count wraps from 0xFF to 0, and the overflow flag is high in the cycle after the wrapping tick.
- R4: In clear-on-compare mode the count goes to 0 on the tick where it equals compare A, and the overflow flag pulses for that tick.
- R5: In phase-correct modes the count rises to TOP, then falls to 0, reversing direction at each end. The overflow flag pulses for the tick taken at 0 while counting down.
- R6: In normal and clear-on-compare modes a channel's 2-bit code acts on a compare match: 00 leaves the pin unchanged, 01 toggles it, 10 clears it, 11 sets it.
- R7: In fast PWM, code 10 clears the pin on a match and sets it when the count wraps to 0. Code 11 sets it on a match and clears it at the wrap.
- R8: In phase-correct PWM, code 10 clears the pin on a match while counting up and sets it on a match while counting down. Code 11 does the reverse.
- R9: In either PWM mode, code 01 toggles channel A's pin on a match only when mode bit 2 is 1, and otherwise leaves it unchanged. On channel B, code 01 always leaves the pin unchanged.
- R10: In a PWM mode with the high code bit set and a compare value equal to TOP, the match is ignored. At TOP the pin is driven to the level of the mode's other action: the wrap level in fast PWM, the counting-down level in phase-correct PWM.
- R11: A channel's override-enable is high exactly when its 2-bit code is nonzero. Writing the code does not change the pin.
- R12: In non-PWM modes a compare write takes effect at once. In PWM modes the active compare value is reloaded from the written value only on the tick taken at TOP.
- R13: A channel's compare flag is high in the cycle after any tick on which the count equals that channel's active compare value.
- R14: The count and the pins change only on a tick or, for the count, on a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tick | input | 1 | Count enable, one step per high cycle |
| pin_a | output | 1 | Channel A waveform |
| pin_a_oe | output | 1 | Channel A override-enable |
| pin_b | output | 1 | Channel B waveform |
| pin_b_oe | output | 1 | Channel B override-enable |
| ovf_flag | output | 1 | Overflow pulse |
| cmp_a_flag | output | 1 | Channel A match pulse |
| cmp_b_flag | output | 1 | Channel B match pulse |

## Verification
The bench runs the counter in every mode with the count preloaded just before the events of interest, and steps it with single ticks. In clear-on-compare mode it steps through all four output codes and a mid-run compare write, which separates immediate from buffered compare updates. In fast PWM it writes a new compare value between TOP events, which shows whether the old value stays active until the wrap. In phase-correct mode it forces matches on both slopes and a compare value equal to TOP, which separates the direction-dependent action from the special case. Code 01 is tried on both channels with mode bit 2 set and cleared, which exposes any toggling on the channel or mode that must stay quiet.

// File: rtl/wavetimer8_pkg.sv
package wavetimer8_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTLA = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTLB = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

  typedef struct packed {
    logic fast;   // single-slope PWM
    logic phase;  // dual-slope PWM
    logic top_a;  // TOP taken from compare A
  } mode_t;

  function automatic mode_t decode_mode(input logic [2:0] w);
    mode_t m;
    m = '0;
    case (w)
      3'b001: m.phase = 1'b1;
      3'b101: begin m.phase = 1'b1; m.top_a = 1'b1; end
      3'b010: m.top_a = 1'b1;
      3'b011: m.fast = 1'b1;
      3'b111: begin m.fast = 1'b1; m.top_a = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] top,
  input  logic         phase,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         at_top,
  output logic         ovf_flag
);
  logic at_bot;

  always_comb begin
    at_top = tick && (cnt == top);
    at_bot = tick && down && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      down     <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      ovf_flag <= phase ? at_bot : at_top;
      if (load) begin
        cnt <= load_val;
      end else if (tick) begin
        if (phase) begin
          if (!down) begin
            if (cnt == top) begin
              down <= 1'b1;
              cnt  <= cnt - 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt == '0) begin
            down <= 1'b0;
            cnt  <= cnt + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          down <= 1'b0;
          cnt  <= (cnt == top) ? '0 : cnt + 1'b1;
        end
      end
    end
  end

  assert_cnt_holds_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
  assert_dir_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(down));
  assert_ovf_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> $past(tick));
  assert_ovf_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !tick) |=> !ovf_flag);
endmodule

// File: rtl/wt_channel.sv
module wt_channel
  import wavetimer8_pkg::*;
#(
  parameter int W = 8,
  parameter bit IS_A = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top,
  input  logic         at_top,
  input  logic         down,
  input  mode_t        mode,
  input  logic         mbit2,
  input  logic [1:0]   code,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cmp_buf,
  output logic [W-1:0] cmp_act,
  output logic         pin,
  output logic         oe,
  output logic         match_flag
);
  logic pwm, match, at_top_eq, pin_nx;

  always_comb begin
    pwm       = mode.fast || mode.phase;
    match     = tick && (cnt == cmp_act);
    at_top_eq = (cmp_act == top);
    oe        = |code;
    pin_nx    = pin;
    if (!pwm) begin
      if (match) begin
        case (code)
          2'b01:   pin_nx = ~pin;
          2'b10:   pin_nx = 1'b0;
          2'b11:   pin_nx = 1'b1;
          default: pin_nx = pin;
        endcase
      end
    end else if (code[1]) begin
      if (mode.fast) begin
        if (at_top)                     pin_nx = ~code[0];
        else if (match && !at_top_eq)   pin_nx = code[0];
      end else begin
        if (at_top && at_top_eq)        pin_nx = ~code[0];
        else if (match && !at_top_eq)   pin_nx = down ? ~code[0] : code[0];
      end
    end else if (code[0] && IS_A && mbit2 && match) begin
      pin_nx = ~pin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf    <= '0;
      cmp_act    <= '0;
      pin        <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      if (cmp_wr) cmp_buf <= cmp_wdata;
      if (!pwm)        cmp_act <= cmp_wr ? cmp_wdata : cmp_buf;
      else if (at_top) cmp_act <= cmp_buf;
      pin        <= pin_nx;
      match_flag <= match;
    end
  end

  assert_pin_on_tick_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pin));
  assert_off_code_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b00) |=> $stable(pin));
  assert_match_after_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag |-> $past(tick));
  assert_pwm_cmp_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !at_top) |=> $stable(cmp_act));
endmodule

// File: rtl/wavetimer8.sv
module wavetimer8
  import wavetimer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              tick,
  output logic              pin_a,
  output logic              pin_a_oe,
  output logic              pin_b,
  output logic              pin_b_oe,
  output logic              ovf_flag,
  output logic              cmp_a_flag,
  output logic              cmp_b_flag
);
  localparam int NCH = 2;

  logic [1:0]   code [NCH];
  logic [1:0]   mlo;
  logic         mbit2;
  mode_t        mode;
  logic [W-1:0] cnt, top;
  logic         down, at_top;
  logic [W-1:0] cbuf [NCH];
  logic [W-1:0] cact [NCH];
  logic [NCH-1:0] pins, oes, mflags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code[0] <= '0;
      code[1] <= '0;
      mlo     <= '0;
      mbit2   <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTLA) begin
        code[0] <= reg_wdata[7:6];
        code[1] <= reg_wdata[5:4];
        mlo     <= reg_wdata[1:0];
      end
      if (reg_addr == A_CTLB) mbit2 <= reg_wdata[0];
    end
  end

  always_comb begin
    mode = decode_mode({mbit2, mlo});
    top  = mode.top_a ? cact[0] : '1;
  end

  wt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(reg_wr && (reg_addr == A_CNT)), .load_val(reg_wdata),
    .top(top), .phase(mode.phase), .cnt(cnt), .down(down),
    .at_top(at_top), .ovf_flag(ovf_flag)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    wt_channel #(.W(W), .IS_A(gi == 0)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .top(top),
      .at_top(at_top), .down(down), .mode(mode), .mbit2(mbit2),
      .code(code[gi]),
      .cmp_wr(reg_wr && (reg_addr == (A_CMPA + ADDR_W'(gi)))),
      .cmp_wdata(reg_wdata), .cmp_buf(cbuf[gi]), .cmp_act(cact[gi]),
      .pin(pins[gi]), .oe(oes[gi]), .match_flag(mflags[gi])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTLA: reg_rdata[7:0] = {code[0], code[1], 2'b00, mlo};
      A_CTLB: reg_rdata[0]   = mbit2;
      A_CMPA: reg_rdata      = cbuf[0];
      A_CMPB: reg_rdata      = cbuf[1];
      A_CNT:  reg_rdata      = cnt;
      default: reg_rdata     = '0;
    endcase
    pin_a      = pins[0];
    pin_b      = pins[1];
    pin_a_oe   = oes[0];
    pin_b_oe   = oes[1];
    cmp_a_flag = mflags[0];
    cmp_b_flag = mflags[1];
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTLA) |-> (reg_rdata[3:2] == 2'b00));
  assert_oe_no_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && reg_wr && reg_addr == A_CTLA) |=> ($stable(pin_a) && $stable(pin_b)));
endmodule

// File: tb/wavetimer8_bench.sv
module wavetimer8_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick = 1'b0;
  logic       pin_a, pin_a_oe, pin_b, pin_b_oe, ovf_flag, cmp_a_flag, cmp_b_flag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wavetimer8 u_wavetimer8 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .pin_a(pin_a), .pin_a_oe(pin_a_oe), .pin_b(pin_b), .pin_b_oe(pin_b_oe),
    .ovf_flag(ovf_flag), .cmp_a_flag(cmp_a_flag), .cmp_b_flag(cmp_b_flag)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) rdchk("R1 reg", 3'(a), 8'h00);
    chk("R1 pins", {pin_a, pin_b, pin_a_oe, pin_b_oe}, 0);
    chk("R1 flags", {ovf_flag, cmp_a_flag, cmp_b_flag}, 0);
  endtask

  task automatic t_regs;
    wr(0, 8'hFF); rdchk("R2 ctla rsvd", 0, 8'hF3);
    chk("R11 oe both", {pin_a_oe, pin_b_oe}, 2'b11);
    chk("R11 pins untouched", {pin_a, pin_b}, 2'b00);
    wr(1, 8'hFF); rdchk("R2 ctlb", 1, 8'h01);
    wr(1, 8'h00);
    wr(0, 8'h40); chk("R11 oe a only", {pin_a_oe, pin_b_oe}, 2'b10);
    wr(0, 8'h10); chk("R11 oe b only", {pin_a_oe, pin_b_oe}, 2'b01);
    wr(0, 8'h00);
    wr(2, 8'h5A); rdchk("R2 cmpa", 2, 8'h5A);
    wr(3, 8'hA5); rdchk("R2 cmpb", 3, 8'hA5);
  endtask

  task automatic t_normal;
    wr(4, 8'hFD); tk(1);
    rdchk("R3 count", 4, 8'hFE); chk("R3 no ovf", ovf_flag, 0);
    tk(1); rdchk("R3 count max", 4, 8'hFF);
    tk(1); rdchk("R3 wrap", 4, 8'h00); chk("R3 ovf", ovf_flag, 1);
    repeat (5) @(negedge clk);
    rdchk("R14 idle count", 4, 8'h00); chk("R14 ovf drop", ovf_flag, 0);
  endtask

  task automatic t_ctc;
    wr(2, 8'd5); wr(3, 8'd3); wr(4, 8'd0); wr(0, 8'h72);
    tk(3); rdchk("R4 count", 4, 8'd3); chk("R6 b before", pin_b, 0);
    tk(1); chk("R6 set b", pin_b, 1); chk("R13 cmp b", cmp_b_flag, 1);
    chk("R13 no cmp a", cmp_a_flag, 0);
    tk(2); rdchk("R4 clear", 4, 8'd0); chk("R4 ovf", ovf_flag, 1);
    chk("R6 toggle a", pin_a, 1); chk("R13 cmp a", cmp_a_flag, 1);
    wr(0, 8'h62); tk(4); chk("R6 clear b", pin_b, 0);
    tk(2); chk("R6 toggle a back", pin_a, 0); rdchk("R4 count0", 4, 8'd0);
    wr(0, 8'h22); tk(6); chk("R6 a disconnected", pin_a, 0);
    wr(2, 8'd3); tk(4); rdchk("R12 immediate", 4, 8'd0);
  endtask

  task automatic t_fast;
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h10); wr(3, 8'h20); wr(0, 8'hB3);
    wr(4, 8'hFE); tk(2);
    chk("R7 a set at wrap", pin_a, 1); chk("R7 b clear at wrap", pin_b, 0);
    wr(4, 8'h10); tk(1); chk("R7 a clear on match", pin_a, 0);
    wr(4, 8'h20); tk(1); chk("R7 b set on match", pin_b, 1);
    wr(4, 8'hFF); tk(1); chk("R7 a wrap", pin_a, 1); chk("R7 b wrap", pin_b, 0);
    wr(2, 8'h30); rdchk("R12 read buffer", 2, 8'h30);
    wr(4, 8'h10); tk(1); chk("R12 old active", pin_a, 0);
    wr(4, 8'hFF); tk(1); chk("R12 wrap set", pin_a, 1);
    wr(4, 8'h10); tk(1); chk("R12 old gone", pin_a, 1);
    wr(4, 8'h30); tk(1); chk("R12 new active", pin_a, 0);
  endtask

  task automatic t_phase;
    wr(0, 8'h00); wr(2, 8'h40); wr(3, 8'h80); wr(0, 8'hA1);
    wr(4, 8'hFE); tk(1); rdchk("R5 up", 4, 8'hFF);
    tk(1); rdchk("R5 turn", 4, 8'hFE); chk("R5 no ovf top", ovf_flag, 0);
    wr(4, 8'h80); tk(1); chk("R8 b down set", pin_b, 1); rdchk("R5 down", 4, 8'h7F);
    wr(4, 8'h40); tk(1); chk("R8 a down set", pin_a, 1);
    wr(4, 8'h01); tk(1); rdchk("R5 bottom", 4, 8'h00);
    tk(1); rdchk("R5 rise", 4, 8'h01); chk("R5 ovf bottom", ovf_flag, 1);
    wr(4, 8'h40); tk(1); chk("R8 a up clear", pin_a, 0);
    wr(4, 8'h80); tk(1); chk("R8 b up clear", pin_b, 0);
  endtask

  task automatic t_toggle;
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h10); wr(3, 8'h08);
    wr(1, 8'h01); wr(0, 8'h53);
    wr(4, 8'h08); tk(1); chk("R9 b stays", pin_b, 0);
    wr(4, 8'h10); tk(1); chk("R9 a toggles", pin_a, 1);
    rdchk("R3 top from cmp a", 4, 8'h00);
    wr(1, 8'h00);
    wr(4, 8'h10); tk(1); chk("R9 a quiet bit2 low", pin_a, 1);
  endtask

  task automatic t_special;
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'hFF); wr(3, 8'hFF); wr(0, 8'hB3);
    wr(4, 8'hFE); tk(2);
    chk("R10 fast a", pin_a, 1); chk("R10 fast b", pin_b, 0);
    chk("R13 flag at top", cmp_a_flag, 1);
    wr(0, 8'hE1);
    wr(4, 8'hFE); tk(2);
    chk("R10 phase a", pin_a, 0); chk("R10 phase b", pin_b, 1);
    rdchk("R10 turned", 4, 8'hFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_regs; t_normal; t_ctc; t_fast; t_phase; t_toggle; t_special;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule